// File: doc/BRIEF.md
# Ternary reversible nine-way selector

The block picks one of nine ternary data digits, using two ternary select digits, and delivers it on a single ternary output. A trit is carried on two wires. The digit 0 is 2'b00, the digit 1 is 2'b01 and the digit 2 is 2'b10. The code 2'b11 is illegal.

Internally the design follows a reversible construction. A one-hot decoder has nine work lines that rest at 0, and it raises the chosen line to the value 2. Each decoder line controls a gate that adds modulo 3. The nine gates form a chain, and each one may add its data digit onto an output line that starts at the constant 0. Only one gate is active, so the line ends up holding the selected digit.

Every select and data digit also leaves the block unchanged. A consumer can therefore rebuild the complete input from the outputs. A flag reports any illegal code on any input. The block is purely combinational.

Top module: `tern_mux9`

## Requirements
- R1: With legal codes on every input, `mux_o` equals data digit k. Data digit k occupies `data_i[2k+1:2k]`. The trit codes are 2'b00 = 0, 2'b01 = 1 and 2'b10 = 2.
- R2: The select index k is computed as 3·A1 + A0. A0 is `sel_i[1:0]` and A1 is `sel_i[3:2]`. For example, A1A0 = 00 picks digit 0, 01 picks 1, 02 picks 2, 10 picks 3 and 22 picks 8.
- R3: `sel_o` equals `sel_i` at all times, including when a code is illegal.
- R4: `data_o` equals `data_i` at all times, including when a code is illegal.
- R5: `err_o` is 1 exactly when at least one 2-bit field of `sel_i` or `data_i` holds 2'b11.
- R6: While `err_o` is 1, `mux_o` is 2'b00.
- R7: Data digits other than the selected one have no effect on `mux_o`.
- R8: `mux_o` never carries the illegal code 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel_i | input | 4 | Select digits: A1 in [3:2], A0 in [1:0] |
| data_i | input | 18 | Nine data digits, digit k at [2k+1:2k] |
| sel_o | output | 4 | Select digits passed through |
| data_o | output | 18 | Data digits passed through |
| mux_o | output | 2 | Selected digit, or 0 when any code is illegal |
| err_o | output | 1 | An illegal 2'b11 code is present on some input |

## Verification
Suppose a decoder line is stuck at 2, or a gate in the chain adds when it should not. The output line then holds a modulo-3 sum of several digits, and this differs from the selected digit for most data patterns. The same fault holds for any select value, and the block has no state. A wrong sum therefore appears on `mux_o` in the same cycle that the inputs are applied. Faults in the pass-through or in the code check appear directly on `sel_o`, `data_o` or `err_o` for the first vector that contains the affected digit.

// File: rtl/tern_pkg.sv
package tern_pkg;
  typedef logic [1:0] trit_t;

  localparam trit_t T_ZERO = 2'b00;
  localparam trit_t T_ONE  = 2'b01;
  localparam trit_t T_TWO  = 2'b10;
  localparam trit_t T_BAD  = 2'b11;

  // modulo-3 sum of two legal trits
  function automatic trit_t gf3_add(trit_t a, trit_t b);
    logic [2:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= 3'd3) s = s - 3'd3;
    return s[1:0];
  endfunction
endpackage

// File: rtl/tern_code_check.sv
module tern_code_check #(
  parameter int N_TRIT = 11
) (
  input  logic [2*N_TRIT-1:0] vec_i,
  output logic                bad_o
);
  logic [N_TRIT-1:0] bad_v;

  for (genvar g = 0; g < N_TRIT; g++) begin : g_trit
    assign bad_v[g] = (vec_i[2*g +: 2] == tern_pkg::T_BAD);
  end

  assign bad_o = |bad_v;
endmodule

// File: rtl/tern_decoder.sv
module tern_decoder #(
  parameter int N_SEL  = 2,
  localparam int N_LINE = 3 ** N_SEL
) (
  input  logic [2*N_SEL-1:0]  sel_i,
  output logic [2*N_SEL-1:0]  sel_o,
  output logic [2*N_LINE-1:0] line_o
);
  import tern_pkg::*;

  int unsigned idx;

  // most significant digit sits in the top field
  always_comb begin
    idx = 0;
    for (int d = N_SEL - 1; d >= 0; d--) begin
      idx = idx * 3 + int'(sel_i[2*d +: 2]);
    end
  end

  // work lines rest at 0, the chosen one is raised to 2
  for (genvar g = 0; g < N_LINE; g++) begin : g_line
    assign line_o[2*g +: 2] = (idx == g) ? T_TWO : T_ZERO;
  end

  assign sel_o = sel_i;
endmodule

// File: rtl/tern_ctrl_adder.sv
module tern_ctrl_adder (
  input  tern_pkg::trit_t ctrl_i,
  input  tern_pkg::trit_t a_i,
  input  tern_pkg::trit_t b_i,
  output tern_pkg::trit_t a_o,
  output tern_pkg::trit_t b_o
);
  import tern_pkg::*;

  assign a_o = a_i;
  assign b_o = (ctrl_i == T_TWO) ? gf3_add(a_i, b_i) : b_i;
endmodule

// File: rtl/tern_mux9.sv
module tern_mux9 #(
  parameter int N_SEL  = 2,
  localparam int N_DATA = 3 ** N_SEL
) (
  input  logic [2*N_SEL-1:0]  sel_i,
  input  logic [2*N_DATA-1:0] data_i,
  output logic [2*N_SEL-1:0]  sel_o,
  output logic [2*N_DATA-1:0] data_o,
  output logic [1:0]          mux_o,
  output logic                err_o
);
  import tern_pkg::*;

  logic [2*N_DATA-1:0] line;
  trit_t               acc [N_DATA+1];
  logic                bad;

  tern_decoder #(.N_SEL(N_SEL)) u_dec (
    .sel_i  (sel_i),
    .sel_o  (sel_o),
    .line_o (line)
  );

  tern_code_check #(.N_TRIT(N_SEL + N_DATA)) u_chk_code (
    .vec_i ({sel_i, data_i}),
    .bad_o (bad)
  );

  // target line enters the chain at constant 0
  assign acc[0] = T_ZERO;

  for (genvar g = 0; g < N_DATA; g++) begin : g_stage
    tern_ctrl_adder u_add (
      .ctrl_i (line[2*g +: 2]),
      .a_i    (data_i[2*g +: 2]),
      .b_i    (acc[g]),
      .a_o    (data_o[2*g +: 2]),
      .b_o    (acc[g+1])
    );
  end

  assign err_o = bad;
  assign mux_o = bad ? T_ZERO : acc[N_DATA];
endmodule

// File: rtl/tern_mux9_chk.sv
module tern_mux9_chk #(
  parameter int N_SEL  = 2,
  localparam int N_DATA = 3 ** N_SEL
) (
  input logic [2*N_SEL-1:0]  sel_i,
  input logic [2*N_DATA-1:0] data_i,
  input logic [2*N_SEL-1:0]  sel_o,
  input logic [2*N_DATA-1:0] data_o,
  input logic [1:0]          mux_o,
  input logic                err_o
);
  int unsigned k;
  logic        any_bad;

  always_comb begin
    k = 0;
    any_bad = 1'b0;
    for (int d = N_SEL - 1; d >= 0; d--) begin
      k = k * 3 + int'(sel_i[2*d +: 2]);
      if (sel_i[2*d +: 2] == 2'b11) any_bad = 1'b1;
    end
    for (int d = 0; d < N_DATA; d++) begin
      if (data_i[2*d +: 2] == 2'b11) any_bad = 1'b1;
    end

    p_pass_sel_r3: assert (sel_o == sel_i);
    p_pass_data_r4: assert (data_o == data_i);
    p_flag_r5: assert (err_o == any_bad);
    p_legal_out_r8: assert (mux_o != 2'b11);
    if (err_o) begin
      p_zero_on_err_r6: assert (mux_o == 2'b00);
    end
    if (!any_bad && k < N_DATA) begin
      p_route_r1: assert (mux_o == data_i[2*k +: 2]);
    end
  end
endmodule

bind tern_mux9 tern_mux9_chk #(.N_SEL(N_SEL)) u_mux9_chk (
  .sel_i  (sel_i),
  .data_i (data_i),
  .sel_o  (sel_o),
  .data_o (data_o),
  .mux_o  (mux_o),
  .err_o  (err_o)
);

// File: tb/tern_mux9_tb_top.sv
module tern_mux9_tb_top;
  typedef struct {
    logic [3:0]  sel;
    logic [17:0] data;
    logic [1:0]  mux;
    logic        err;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  sel_i = '0;
  logic [17:0] data_i = '0;
  logic [3:0]  sel_o;
  logic [17:0] data_o;
  logic [1:0]  mux_o;
  logic        err_o;

  int checks = 0;
  int errors = 0;
  item_t q[$];

  always #2 clk = ~clk;

  tern_mux9 dut_i (
    .sel_i  (sel_i),
    .data_i (data_i),
    .sel_o  (sel_o),
    .data_o (data_o),
    .mux_o  (mux_o),
    .err_o  (err_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] rnd_data();
    logic [17:0] d;
    for (int i = 0; i < 9; i++) d[2*i +: 2] = 2'($urandom % 3);
    return d;
  endfunction

  // reference: index = 3*A1 + A0, illegal code forces 0
  task automatic drive(logic [3:0] sel, logic [17:0] data, string tag);
    item_t it;
    logic bad;
    int k;
    bad = 1'b0;
    for (int i = 0; i < 2; i++) if (sel[2*i +: 2] == 2'b11) bad = 1'b1;
    for (int i = 0; i < 9; i++) if (data[2*i +: 2] == 2'b11) bad = 1'b1;
    k = 3 * int'(sel[3:2]) + int'(sel[1:0]);
    it.sel  = sel;
    it.data = data;
    it.err  = bad;
    it.mux  = bad ? 2'b00 : data[2*k +: 2];
    it.tag  = tag;
    @(posedge clk);
    sel_i  = sel;
    data_i = data;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(it.tag, 32'(mux_o), 32'(it.mux));
      chk("R5 err", 32'(err_o), 32'(it.err));
      chk("R3 sel", 32'(sel_o), 32'(it.sel));
      chk("R4 data", 32'(data_o), 32'(it.data));
      chk("R8 legal", 32'(mux_o == 2'b11), 32'd0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [17:0] d;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    drive(4'b0000, 18'd0, "R1 reset");

    // R2: every select value against random data
    for (int s = 0; s < 9; s++) begin
      for (int r = 0; r < 4; r++) begin
        drive({2'(s / 3), 2'(s % 3)}, rnd_data(), "R2 index");
      end
    end

    // R1: all digits 2, and a distinct digit at each position
    for (int s = 0; s < 9; s++) drive({2'(s / 3), 2'(s % 3)}, {9{2'b10}}, "R1 all2");
    for (int s = 0; s < 9; s++) begin
      d = '0;
      d[2*s +: 2] = 2'b01;
      drive({2'(s / 3), 2'(s % 3)}, d, "R1 single");
    end

    // R7: select 11 (digit 4 = 1), other digits vary
    for (int r = 0; r < 8; r++) begin
      d = rnd_data();
      d[9:8] = 2'b01;
      drive(4'b0101, d, "R7 unselected");
    end

    // R6: illegal codes in select and in data
    drive(4'b0011, {9{2'b10}}, "R6 bad A0");
    drive(4'b1100, {9{2'b01}}, "R6 bad A1");
    d = {9{2'b10}};
    d[17:16] = 2'b11;
    drive(4'b0000, d, "R6 bad unselected");
    d = {9{2'b01}};
    d[1:0] = 2'b11;
    drive(4'b0000, d, "R6 bad selected");
    drive(4'b0000, {9{2'b01}}, "R1 recover");

    repeat (4) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule